// File: doc/BRIEF.md
# Indexed Register Access Port

This block is an I/O slave on an ISA-style bus. It makes a bank of internal byte registers reachable through just two I/O addresses. A byte written to the index port at 3E0h chooses one location in a flat 256-byte space. Later accesses to the data port at 3E1h read or write whichever location the index currently names. The index byte splits into three fields. Bit 7 names the device, bit 6 names the socket (A = 0, B = 1) and bits 5:0 give the register number.

Two copies of the block can sit on the same pair of addresses. Each copy has a fixed device identity (`DEV_ID`) and a socket count (`NUM_SOCKETS`). Every copy latches every index write, so all copies agree on the current index. Only the copy that the index selects answers the data port. Only device 0 returns the index byte on reads. A 16-bit access at 3E0h carries the index on the low lane and the data port on the high lane. A simple byte array stands in for the real register contents. Register numbers at or above `BACKED_REGS` are reserved.

A small bus-cycle state machine tracks each strobe. Its states are `ST_IDLE` (no cycle in progress), `ST_READ` (read data held on the bus) and `ST_WRITE` (write already committed, waiting for the strobe to end). The transitions are:
- `ST_IDLE` to `ST_READ` when `rd` is high and `wr` is low; the read bytes are captured on this step.
- `ST_IDLE` to `ST_WRITE` when `wr` is high and `rd` is low; the write is committed on this step.
- `ST_READ` to `ST_IDLE` when `rd` falls.
- `ST_WRITE` to `ST_IDLE` when `wr` falls.
- `ST_IDLE` stays in `ST_IDLE` in every other case, including `rd` and `wr` high together.

Top module: `idxport_top`

## Requirements
- R1: After reset the index reads 00h, every register reads 00h and `rd_oe` is 00.
- R2: Every device latches every write to the byte at 3E0h, whatever value bit 7 has. On a read of 3E0h only the `DEV_ID` = 0 device drives that byte with the index. The `DEV_ID` = 1 device never drives it.
- R3: A data-port access reaches the register named by the index: bits 5:0 give the register number and bit 6 gives the socket (0 = A, 1 = B). Each socket has its own storage.
- R4: A device answers the data port only when index bit 7 equals its `DEV_ID` and bit 6 names a socket it implements. Socket A always exists; socket B exists only when `NUM_SOCKETS` = 2. Otherwise the device discards data writes and drives nothing. Two devices never drive the same lane.
- R5: On a selected device, a register number at or above `BACKED_REGS` (default 40, so 28h to 3Fh) reads 00h and discards writes. Number 27h is still backed.
- R6: A 16-bit read at 3E0h (`be` = 11) returns the index on lane 0 and the data-port value on lane 1. The `DEV_ID` = 1 device drives only lane 1.
- R7: A 16-bit write at 3E0h writes the low byte to the index. The high byte goes to the register named by the new index.
- R8: Lane 0 carries the byte at `addr` and lane 1 the byte at `addr`+1. An 8-bit access at 3E1h therefore uses lane 0. Bytes at any other address are ignored: they cause no write and are not driven on reads.
- R9: `rdata` and `rd_oe` become valid one clock after `rd` is first sampled high. They hold while `rd` stays high and return to 00 one clock after `rd` is sampled low.
- R10: A cycle that starts with `rd` and `wr` high together does nothing: no write and no drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | I/O address of lane 0 |
| be | input | 2 | Byte enables; bit 0 is lane 0 (`addr`), bit 1 is lane 1 (`addr`+1) |
| rd | input | 1 | Read strobe, held high for the whole cycle |
| wr | input | 1 | Write strobe, held high for the whole cycle |
| wdata | input | 16 | Write data, lane 0 in bits 7:0 |
| rdata | output | 16 | Read data; undriven lanes read 0 |
| rd_oe | output | 2 | Per-lane output enable for `rdata` |

## Verification
The assertions assume three things about the bus. First, `addr`, `be` and `wdata` stay stable while a strobe is high. Second, every strobe is preceded by at least one cycle with both strobes low. Third, the only addresses used are 3E0h, 3E1h, or ones that do not reach either port. The bench meets all three: each access goes through a task that sets up the bus at a falling edge, holds it for the whole strobe and leaves an idle cycle after it. The one overlap of `rd` and `wr` is a single deliberate cycle used to check R10. Two instances share the bus, one for device 0 with two sockets and one for device 1 with one socket, so device selection and contention are checked on real bus traffic.

// File: rtl/idxport_pkg.sv
package idxport_pkg;

    localparam logic [15:0] IDX_PORT_ADDR = 16'h03E0;
    localparam logic [15:0] DAT_PORT_ADDR = 16'h03E1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic       dev;
        logic       sock;
        logic [5:0] regno;
    } index_t;

endpackage

// File: rtl/idxport_decode.sv
module idxport_decode
    import idxport_pkg::*;
#(
    parameter int DEV_ID      = 0,
    parameter int NUM_SOCKETS = 2
) (
    input  logic [15:0] addr,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    input  index_t      index_q,
    output logic [1:0]  lane_idx,
    output logic [1:0]  lane_dat,
    output logic        idx_hit,
    output index_t      eff_index,
    output logic        dat_hit,
    output logic [7:0]  dat_wbyte,
    output logic        sel_cur,
    output logic        sel_eff
);

    localparam logic DEV_BIT  = DEV_ID[0];
    localparam logic HAS_SOCK_B = (NUM_SOCKETS > 1);

    function automatic logic selects_me(input index_t x);
        return (x.dev == DEV_BIT) && (!x.sock || HAS_SOCK_B);
    endfunction

    for (genvar i = 0; i < 2; i++) begin : g_lane
        logic [15:0] lane_addr;
        assign lane_addr   = addr + 16'(i);
        assign lane_idx[i] = be[i] && (lane_addr == IDX_PORT_ADDR);
        assign lane_dat[i] = be[i] && (lane_addr == DAT_PORT_ADDR);
    end

    logic [7:0] new_idx;

    always_comb begin
        idx_hit   = |lane_idx;
        dat_hit   = |lane_dat;
        new_idx   = lane_idx[1] ? wdata[15:8] : wdata[7:0];
        dat_wbyte = lane_dat[1] ? wdata[15:8] : wdata[7:0];
        eff_index = idx_hit ? index_t'(new_idx) : index_q;
        sel_cur   = selects_me(index_q);
        sel_eff   = selects_me(eff_index);
    end

endmodule

// File: rtl/idxport_regbank.sv
module idxport_regbank #(
    parameter int NUM_SOCKETS = 2,
    parameter int BACKED_REGS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       wsock,
    input  logic [5:0] wreg,
    input  logic [7:0] wbyte,
    input  logic       rsock,
    input  logic [5:0] rreg,
    output logic [7:0] rbyte
);

    localparam int         REG_AW     = $clog2(BACKED_REGS);
    localparam logic [6:0] BACKED_LIM = 7'(BACKED_REGS);

    logic [7:0] sock_rd [NUM_SOCKETS];
    logic       wr_backed;
    logic       rd_backed;

    assign wr_backed = ({1'b0, wreg} < BACKED_LIM);
    assign rd_backed = ({1'b0, rreg} < BACKED_LIM);

    for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
        logic [7:0] mem [BACKED_REGS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < BACKED_REGS; k++) begin
                    mem[k] <= 8'h00;
                end
            end else if (we && wr_backed && (wsock == 1'(s))) begin
                mem[wreg[REG_AW-1:0]] <= wbyte;
            end
        end

        assign sock_rd[s] = rd_backed ? mem[rreg[REG_AW-1:0]] : 8'h00;
    end

    always_comb begin
        rbyte = 8'h00;
        for (int s = 0; s < NUM_SOCKETS; s++) begin
            if (rsock == 1'(s)) begin
                rbyte = sock_rd[s];
            end
        end
    end

endmodule

// File: rtl/idxport_busfsm.sv
module idxport_busfsm
    import idxport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic        wr,
    input  logic [15:0] rd_bytes,
    input  logic [1:0]  rd_drive,
    output logic        commit,
    output logic [15:0] rdata,
    output logic [1:0]  rd_oe
);

    bus_state_t state_q;
    bus_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd && !wr)      state_d = ST_READ;
                else if (wr && !rd) state_d = ST_WRITE;
            end
            ST_READ:  if (!rd) state_d = ST_IDLE;
            ST_WRITE: if (!wr) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign commit = (state_q == ST_IDLE) && wr && !rd;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 16'h0000;
            rd_oe <= 2'b00;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rd && !wr) begin
                        rd_oe <= rd_drive;
                        rdata <= rd_bytes & {{8{rd_drive[1]}}, {8{rd_drive[0]}}};
                    end else begin
                        rd_oe <= 2'b00;
                        rdata <= 16'h0000;
                    end
                end
                ST_READ: begin
                    if (!rd) begin
                        rd_oe <= 2'b00;
                        rdata <= 16'h0000;
                    end
                end
                default: begin
                    rd_oe <= 2'b00;
                    rdata <= 16'h0000;
                end
            endcase
        end
    end

endmodule

// File: rtl/idxport_top.sv
module idxport_top
    import idxport_pkg::*;
#(
    parameter int DEV_ID      = 0,
    parameter int NUM_SOCKETS = 2,
    parameter int BACKED_REGS = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [1:0]  be,
    input  logic        rd,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic [1:0]  rd_oe
);

    localparam logic IDX_OWNER = (DEV_ID == 0);

    index_t      index_q;
    index_t      eff_index;
    logic [1:0]  lane_idx;
    logic [1:0]  lane_dat;
    logic        idx_hit;
    logic        dat_hit;
    logic [7:0]  dat_wbyte;
    logic        sel_cur;
    logic        sel_eff;
    logic        commit;
    logic [7:0]  reg_rbyte;
    logic [15:0] rd_bytes;
    logic [1:0]  rd_drive;

    idxport_decode #(
        .DEV_ID      (DEV_ID),
        .NUM_SOCKETS (NUM_SOCKETS)
    ) decode_i (
        .addr      (addr),
        .be        (be),
        .wdata     (wdata),
        .index_q   (index_q),
        .lane_idx  (lane_idx),
        .lane_dat  (lane_dat),
        .idx_hit   (idx_hit),
        .eff_index (eff_index),
        .dat_hit   (dat_hit),
        .dat_wbyte (dat_wbyte),
        .sel_cur   (sel_cur),
        .sel_eff   (sel_eff)
    );

    idxport_busfsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (rd),
        .wr       (wr),
        .rd_bytes (rd_bytes),
        .rd_drive (rd_drive),
        .commit   (commit),
        .rdata    (rdata),
        .rd_oe    (rd_oe)
    );

    idxport_regbank #(
        .NUM_SOCKETS (NUM_SOCKETS),
        .BACKED_REGS (BACKED_REGS)
    ) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit && dat_hit && sel_eff),
        .wsock (eff_index.sock),
        .wreg  (eff_index.regno),
        .wbyte (dat_wbyte),
        .rsock (index_q.sock),
        .rreg  (index_q.regno),
        .rbyte (reg_rbyte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (commit && idx_hit) index_q <= eff_index;
    end

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            rd_bytes[i*8 +: 8] = 8'h00;
            rd_drive[i]        = 1'b0;
            if (lane_idx[i]) begin
                rd_bytes[i*8 +: 8] = index_q;
                rd_drive[i]        = IDX_OWNER;
            end else if (lane_dat[i]) begin
                rd_bytes[i*8 +: 8] = reg_rbyte;
                rd_drive[i]        = sel_cur;
            end
        end
    end

endmodule

// File: rtl/idxport_chk.sv
module idxport_chk #(
    parameter int DEV_ID      = 0,
    parameter int NUM_SOCKETS = 2,
    parameter int BACKED_REGS = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic [1:0]  be,
    input logic        rd,
    input logic        wr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic [1:0]  rd_oe,
    input logic [7:0]  index_q
);

    localparam logic [6:0] LIM   = 7'(BACKED_REGS);
    localparam logic       DEVB  = DEV_ID[0];
    localparam logic       HAS_B = (NUM_SOCKETS > 1);

    // R2
    index_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd) && !$past(wr) && wr && !rd && addr == 16'h03E0 && be[0])
        |=> (index_q == $past(wdata[7:0])));

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rd_oe == 2'b00));

    // R4
    data_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe[1] && addr == 16'h03E0)
        |-> (index_q[7] == DEVB && (!index_q[6] || HAS_B)));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe[1] && addr == 16'h03E0 && {1'b0, index_q[5:0]} >= LIM)
        |-> (rdata[15:8] == 8'h00));

    if (DEV_ID != 0) begin : g_dev1
        // R2
        no_index_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_oe[0] |-> (addr != 16'h03E0));
    end

endmodule

bind idxport_top idxport_chk #(
    .DEV_ID      (DEV_ID),
    .NUM_SOCKETS (NUM_SOCKETS),
    .BACKED_REGS (BACKED_REGS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .be      (be),
    .rd      (rd),
    .wr      (wr),
    .wdata   (wdata),
    .rdata   (rdata),
    .rd_oe   (rd_oe),
    .index_q (index_q)
);

// File: tb/idxport_top_tb_top.sv
module idxport_top_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        is_rd;
        logic [15:0] addr;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] exp_d;
        logic [1:0]  exp_oe;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h03E0, 2'b01, 16'h0005, 16'h0000, 2'b00, 8'd3}, // R3 dev0 A reg05
        '{1'b0, 16'h03E1, 2'b01, 16'h00A5, 16'h0000, 2'b00, 8'd3},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h00A5, 2'b01, 8'd3},
        '{1'b1, 16'h03E0, 2'b01, 16'h0000, 16'h0005, 2'b01, 8'd2}, // R2 readback
        '{1'b0, 16'h03E0, 2'b01, 16'h0045, 16'h0000, 2'b00, 8'd3}, // socket B
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h0000, 2'b01, 8'd3},
        '{1'b0, 16'h03E1, 2'b01, 16'h005B, 16'h0000, 2'b00, 8'd3},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h005B, 2'b01, 8'd3},
        '{1'b0, 16'h03E0, 2'b01, 16'h0005, 16'h0000, 2'b00, 8'd3},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h00A5, 2'b01, 8'd3},
        '{1'b0, 16'h03E0, 2'b01, 16'h0085, 16'h0000, 2'b00, 8'd2}, // R2 dev1 index
        '{1'b1, 16'h03E0, 2'b01, 16'h0000, 16'h0085, 2'b01, 8'd2},
        '{1'b0, 16'h03E1, 2'b01, 16'h00C3, 16'h0000, 2'b00, 8'd3},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h00C3, 2'b01, 8'd3},
        '{1'b0, 16'h03E0, 2'b01, 16'h0005, 16'h0000, 2'b00, 8'd4}, // R4
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h00A5, 2'b01, 8'd4},
        '{1'b0, 16'h03E0, 2'b01, 16'h00C5, 16'h0000, 2'b00, 8'd4}, // dev1 socket B absent
        '{1'b0, 16'h03E1, 2'b01, 16'h0077, 16'h0000, 2'b00, 8'd4},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h0000, 2'b00, 8'd4},
        '{1'b0, 16'h03E0, 2'b01, 16'h0045, 16'h0000, 2'b00, 8'd4},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h005B, 2'b01, 8'd4},
        '{1'b0, 16'h03E0, 2'b01, 16'h0030, 16'h0000, 2'b00, 8'd5}, // R5 reserved
        '{1'b0, 16'h03E1, 2'b01, 16'h00FF, 16'h0000, 2'b00, 8'd5},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h0000, 2'b01, 8'd5},
        '{1'b0, 16'h03E0, 2'b01, 16'h0027, 16'h0000, 2'b00, 8'd5}, // last backed
        '{1'b0, 16'h03E1, 2'b01, 16'h0011, 16'h0000, 2'b00, 8'd5},
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h0011, 2'b01, 8'd5},
        '{1'b0, 16'h03E0, 2'b11, 16'h3C06, 16'h0000, 2'b00, 8'd7}, // R7
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h003C, 2'b01, 8'd7},
        '{1'b1, 16'h03E0, 2'b11, 16'h0000, 16'h3C06, 2'b11, 8'd6}, // R6
        '{1'b0, 16'h03E0, 2'b01, 16'h0085, 16'h0000, 2'b00, 8'd6},
        '{1'b1, 16'h03E0, 2'b11, 16'h0000, 16'hC385, 2'b11, 8'd6},
        '{1'b0, 16'h03E0, 2'b01, 16'h0007, 16'h0000, 2'b00, 8'd8}, // R8
        '{1'b0, 16'h03E1, 2'b11, 16'h9944, 16'h0000, 2'b00, 8'd8},
        '{1'b1, 16'h03E1, 2'b11, 16'h0000, 16'h0044, 2'b01, 8'd8},
        '{1'b0, 16'h03E2, 2'b01, 16'h0000, 16'h0000, 2'b00, 8'd8},
        '{1'b0, 16'h0370, 2'b01, 16'h0055, 16'h0000, 2'b00, 8'd8},
        '{1'b1, 16'h03E0, 2'b01, 16'h0000, 16'h0007, 2'b01, 8'd8},
        '{1'b0, 16'h03E0, 2'b01, 16'h00B0, 16'h0000, 2'b00, 8'd5}, // dev1 reserved
        '{1'b1, 16'h03E1, 2'b01, 16'h0000, 16'h0000, 2'b01, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [1:0]  be = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata_a, rdata_b;
    logic [1:0]  oe_a, oe_b;
    logic [1:0]  bus_oe;
    logic [15:0] bus_d;

    int n_checks = 0;
    int n_fail   = 0;
    int contention = 0;
    bit done = 1'b0;
    logic [15:0] got_d;
    logic [1:0]  got_oe, got_oe_a, got_oe_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    idxport_top #(.DEV_ID(0), .NUM_SOCKETS(2), .BACKED_REGS(40)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata_a), .rd_oe(oe_a)
    );

    idxport_top #(.DEV_ID(1), .NUM_SOCKETS(1), .BACKED_REGS(40)) peer_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata_b), .rd_oe(oe_b)
    );

    assign bus_oe = oe_a | oe_b;
    assign bus_d[7:0]  = oe_a[0] ? rdata_a[7:0]  : (oe_b[0] ? rdata_b[7:0]  : 8'h00);
    assign bus_d[15:8] = oe_a[1] ? rdata_a[15:8] : (oe_b[1] ? rdata_b[15:8] : 8'h00);

    always @(negedge clk) begin
        if (rst_n && ((oe_a & oe_b) != 2'b00)) contention++;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [1:0] b, input logic [15:0] d);
        @(negedge clk);
        addr = a; be = b; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] b);
        @(negedge clk);
        addr = a; be = b; rd = 1'b1;
        @(negedge clk);
        got_d = bus_d; got_oe = bus_oe; got_oe_a = oe_a; got_oe_b = oe_b;
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 oe idle in reset", {14'h0, bus_oe}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe idle after reset", {14'h0, bus_oe}, 16'h0000);
        do_read(16'h03E0, 2'b01);
        check("R1 index reset", got_d, 16'h0000);
        check("R1 index read oe", {14'h0, got_oe}, 16'h0001);
        do_read(16'h03E1, 2'b01);
        check("R1 register reset", got_d, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) begin
                logic [15:0] m;
                do_read(VEC[i].addr, VEC[i].be);
                m = {{8{VEC[i].exp_oe[1]}}, {8{VEC[i].exp_oe[0]}}};
                check($sformatf("R%0d vec %0d oe", VEC[i].req, i), {14'h0, got_oe}, {14'h0, VEC[i].exp_oe});
                check($sformatf("R%0d vec %0d data", VEC[i].req, i), got_d & m, VEC[i].exp_d & m);
            end else begin
                do_write(VEC[i].addr, VEC[i].be, VEC[i].wd);
            end
        end

        // R6: per-device lanes on a 16-bit read, device 1 selected
        do_write(16'h03E0, 2'b01, 16'h0085);
        do_read(16'h03E0, 2'b11);
        check("R6 dev0 lanes", {14'h0, got_oe_a}, 16'h0001);
        check("R6 dev1 lanes", {14'h0, got_oe_b}, 16'h0002);

        // R9: timing of output enable
        @(negedge clk);
        addr = 16'h03E1; be = 2'b01; rd = 1'b1;
        #1 check("R9 no drive before edge", {14'h0, bus_oe}, 16'h0000);
        @(negedge clk);
        check("R9 drive after one edge", {14'h0, bus_oe}, 16'h0001);
        check("R9 data", bus_d, 16'h00C3);
        @(negedge clk);
        check("R9 held", {14'h0, bus_oe}, 16'h0001);
        rd = 1'b0;
        @(negedge clk);
        check("R9 released", {14'h0, bus_oe}, 16'h0000);

        // R10: overlapping strobes do nothing
        do_write(16'h03E0, 2'b01, 16'h0007);
        @(negedge clk);
        addr = 16'h03E1; be = 2'b01; wdata = 16'h00EE; rd = 1'b1; wr = 1'b1;
        @(negedge clk);
        check("R10 no drive", {14'h0, bus_oe}, 16'h0000);
        rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        do_read(16'h03E1, 2'b01);
        check("R10 no write", got_d, 16'h0044);

        // R1: reset mid-run clears index and storage
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(16'h03E0, 2'b01);
        check("R1 index cleared", got_d, 16'h0000);
        do_write(16'h03E0, 2'b01, 16'h0005);
        do_read(16'h03E1, 2'b01);
        check("R1 register cleared", got_d, 16'h0000);

        // R4: no lane was ever driven by both devices
        check("R4 bus contention events", 16'(contention), 16'h0000);

        finish_run();
    end

endmodule